// File: doc/BRIEF.md
# Four-Channel DMA Priority Arbiter

This block decides which of four DMA channels is served next when more than one of them asks for a transfer at once. A channel is a candidate only while its request bit, its own enable bit and the shared master enable are all high. A 2-bit mode input selects one of three fixed priority orders or a rotating order. The winner is captured in a register and presented both as a one-hot vector and as a channel number with a valid flag.

The registered grant is held until a single-cycle transfer-complete pulse arrives. That pulse frees the grant and moves the rotation pointer past the channel that was just served. A suspend input withdraws any held grant, blocks new grants and freezes the rotation state for as long as it stays high. The surrounding controller owns addressing, bus cycles and transfer counting. This block only arbitrates.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, grantValid is 0, grantOneHot is 4'b0000 and grantIdx is 0. The rotation pointer starts at channel 0, so in rotating mode with all four channels eligible the first grant goes to channel 0.
- R2: Channel n is eligible only when reqVec[n], chanEn[n] and masterEn are all 1. An ineligible channel is never granted.
- R3: With prioMode = 2'b00, the eligible channels rank 0, 1, 2, 3, highest first.
- R4: With prioMode = 2'b01, the eligible channels rank 0, 2, 3, 1, highest first.
- R5: With prioMode = 2'b10, the eligible channels rank 2, 0, 1, 3, highest first.
- R6: With prioMode = 2'b11, the order starts at the rotation pointer and counts upward modulo 4. Each accepted transfer-complete pulse, in any mode, sets the pointer to the served channel plus 1 modulo 4, so the served channel becomes the lowest priority.
- R7: When no grant is held and a channel is eligible at a rising edge, the grant appears after that edge. It then stays at the same channel, ignoring changes to reqVec, chanEn and prioMode, until it is released.
- R8: A xferDone pulse sampled while a grant is held and suspend is low clears the grant at that edge. Arbitration runs again at the following edge.
- R9: A suspend level sampled at an edge clears any held grant at that edge. While suspend stays high, no grant is issued, xferDone is ignored and the rotation pointer keeps its value.
- R10: When no channel is eligible, no grant is issued: grantValid stays 0, grantOneHot stays 4'b0000 and grantIdx stays 0.
- R11: While grantValid is 1, grantOneHot has exactly one bit set, at position grantIdx. While grantValid is 0, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqVec | input | 4 | Transfer request, one bit per channel |
| chanEn | input | 4 | Per-channel enable |
| masterEn | input | 1 | Global enable for all channels |
| suspend | input | 1 | Withdraws and blocks grants, freezes the rotation state |
| prioMode | input | 2 | Priority order select: 00, 01, 10 fixed, 11 rotating |
| xferDone | input | 1 | Single-cycle pulse marking completion of the granted transfer |
| grantOneHot | output | 4 | One-hot grant |
| grantIdx | output | 2 | Number of the granted channel |
| grantValid | output | 1 | A grant is held |

## Verification
The bench targets the two non-monotonic fixed orders. It removes the winner one channel at a time, so a design that treated mode 01 or 10 as simply ascending or descending would give the wrong channel partway through the sequence. It checks that the rotation restarts at channel 0 after reset and moves exactly one position past each served channel, including sparse request patterns where the next request is several positions away. A pointer that skipped, or that advanced on grant instead of on completion, would show up there. The bench also pulses completion during suspend and then expects the same channel to win again, which exposes a design that lets suspended pulses move the pointer. Finally, it changes requests and mode under a held grant to catch a grant that is not truly registered.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int ArbChan = 4;
  localparam int ArbIdxW = $clog2(ArbChan);

  typedef enum logic [1:0] {
    MODE_ASCEND  = 2'b00,
    MODE_SPLIT_A = 2'b01,
    MODE_SPLIT_B = 2'b10,
    MODE_ROTATE  = 2'b11
  } prio_mode_e;

  typedef struct packed {
    logic loadGrant;
    logic clearGrant;
    logic advancePtr;
  } arb_strobe_t;

  // Channel that occupies a given rank (0 = highest) in a fixed order.
  function automatic logic [ArbIdxW-1:0] fixedSlot(input logic [1:0] mode,
                                                   input logic [ArbIdxW-1:0] rank);
    logic [ArbIdxW-1:0] chan;
    chan = rank;
    case (mode)
      MODE_SPLIT_A: begin
        case (rank)
          2'd0:    chan = 2'd0;
          2'd1:    chan = 2'd2;
          2'd2:    chan = 2'd3;
          default: chan = 2'd1;
        endcase
      end
      MODE_SPLIT_B: begin
        case (rank)
          2'd0:    chan = 2'd2;
          2'd1:    chan = 2'd0;
          2'd2:    chan = 2'd1;
          default: chan = 2'd3;
        endcase
      end
      default: chan = rank;
    endcase
    return chan;
  endfunction

endpackage

// File: rtl/dma_arb_ctrl.sv
module dma_arb_ctrl
  import dma_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        suspend,
  input  logic        xferDone,
  input  logic        anyElig,
  output arb_strobe_t strobe
);

  typedef enum logic {ARB_IDLE, ARB_HELD} arb_state_e;

  arb_state_e state;
  arb_state_e stateNext;

  always_comb begin
    strobe     = '0;
    stateNext  = state;
    case (state)
      ARB_IDLE: begin
        if (!suspend && anyElig) begin
          strobe.loadGrant = 1'b1;
          stateNext        = ARB_HELD;
        end
      end
      ARB_HELD: begin
        if (suspend) begin
          strobe.clearGrant = 1'b1;
          stateNext         = ARB_IDLE;
        end else if (xferDone) begin
          strobe.clearGrant = 1'b1;
          strobe.advancePtr = 1'b1;
          stateNext         = ARB_IDLE;
        end
      end
      default: stateNext = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ARB_IDLE;
    else       state <= stateNext;
  end

  // R8: a completion accepted while held returns the controller to idle
  p_done_releases_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ARB_HELD && xferDone && !suspend) |=> (state == ARB_IDLE));

  // R9: suspend never leaves the controller holding a grant
  p_suspend_idles_r9: assert property (@(posedge clk) disable iff (!rstN)
    suspend |=> (state == ARB_IDLE));

endmodule

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter  int NumChan = ArbChan,
  localparam int IdxW    = $clog2(NumChan)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NumChan-1:0] reqVec,
  input  logic [NumChan-1:0] chanEn,
  input  logic               masterEn,
  input  logic [1:0]         prioMode,
  input  arb_strobe_t        strobe,
  output logic               anyElig,
  output logic [NumChan-1:0] grantOneHot,
  output logic [IdxW-1:0]    grantIdx,
  output logic               grantValid
);

  logic [NumChan-1:0] eligVec;
  logic [IdxW-1:0]    rrPtr;
  logic [IdxW-1:0]    rankChan [NumChan];
  logic [NumChan-1:0] rankHit;
  logic [IdxW-1:0]    winIdx;

  assign eligVec = reqVec & chanEn & {NumChan{masterEn}};
  assign anyElig = |eligVec;

  // One slot per rank: which channel sits there and whether it is eligible.
  for (genvar r = 0; r < NumChan; r++) begin : g_rank
    always_comb begin
      if (prioMode == MODE_ROTATE) rankChan[r] = rrPtr + IdxW'(r);
      else                         rankChan[r] = fixedSlot(prioMode, IdxW'(r));
      rankHit[r] = eligVec[rankChan[r]];
    end
  end

  // Highest-ranked hit wins.
  always_comb begin
    winIdx = '0;
    for (int r = NumChan - 1; r >= 0; r--) begin
      if (rankHit[r]) winIdx = rankChan[r];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grantValid <= 1'b0;
      grantIdx   <= '0;
    end else if (strobe.loadGrant) begin
      grantValid <= 1'b1;
      grantIdx   <= winIdx;
    end else if (strobe.clearGrant) begin
      grantValid <= 1'b0;
      grantIdx   <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  rrPtr <= '0;
    else if (strobe.advancePtr) rrPtr <= IdxW'(grantIdx + 1'b1);
  end

  assign grantOneHot = grantValid ? (NumChan'(1) << grantIdx) : '0;

  // R2: a newly issued grant names a channel that was eligible one cycle earlier
  p_grant_was_eligible_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> ((($past(eligVec) >> grantIdx) & NumChan'(1)) != '0));

  // R6: the rotation pointer moves only on an accepted completion
  p_ptr_moves_on_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid) |=> $stable(rrPtr));

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] reqVec,
  input  logic [3:0] chanEn,
  input  logic       masterEn,
  input  logic       suspend,
  input  logic [1:0] prioMode,
  input  logic       xferDone,
  output logic [3:0] grantOneHot,
  output logic [1:0] grantIdx,
  output logic       grantValid
);

  arb_strobe_t strobe;
  logic        anyElig;

  dma_arb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .suspend  (suspend),
    .xferDone (xferDone),
    .anyElig  (anyElig),
    .strobe   (strobe)
  );

  dma_arb_datapath #(.NumChan(ArbChan)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .reqVec      (reqVec),
    .chanEn      (chanEn),
    .masterEn    (masterEn),
    .prioMode    (prioMode),
    .strobe      (strobe),
    .anyElig     (anyElig),
    .grantOneHot (grantOneHot),
    .grantIdx    (grantIdx),
    .grantValid  (grantValid)
  );

  // R7: a held grant stays put until released
  p_grant_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !xferDone && !suspend) |=> (grantValid && $stable(grantIdx)));

  // R9: suspend withdraws the grant at the edge that samples it
  p_suspend_drops_r9: assert property (@(posedge clk) disable iff (!rstN)
    suspend |=> !grantValid);

  // R10: nothing eligible and nothing held means nothing granted
  p_no_elig_no_grant_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!grantValid && ((reqVec & chanEn & {4{masterEn}}) == 4'b0000)) |=> !grantValid);

  // R11: output encodings agree
  p_onehot_match_r11: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ($onehot(grantOneHot) && grantOneHot[grantIdx]));
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> (grantOneHot == 4'b0000 && grantIdx == 2'd0));

endmodule

// File: tb/tb_dma_prio_arbiter.sv
module tb_dma_prio_arbiter;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] reqVec = '0;
  logic [3:0] chanEn = 4'b1111;
  logic       masterEn = 1'b1;
  logic       suspend = 1'b0;
  logic [1:0] prioMode = 2'b00;
  logic       xferDone = 1'b0;
  logic [3:0] grantOneHot;
  logic [1:0] grantIdx;
  logic       grantValid;

  int checkCount = 0;
  int failCount  = 0;
  int rrModel    = 0;
  bit finished   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  dma_prio_arbiter dut (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .chanEn(chanEn),
    .masterEn(masterEn), .suspend(suspend), .prioMode(prioMode),
    .xferDone(xferDone), .grantOneHot(grantOneHot), .grantIdx(grantIdx),
    .grantValid(grantValid)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expectGrant(string tag, bit expValid, int expIdx);
    logic [3:0] expHot;
    logic [1:0] expNum;
    expHot = expValid ? (4'b0001 << expIdx) : 4'b0000;
    expNum = expValid ? 2'(expIdx) : 2'd0;
    checkCount++;
    if (grantValid !== expValid || grantOneHot !== expHot || grantIdx !== expNum) begin
      failCount++;
      $display("FAIL %s: actual valid=%0b hot=%b idx=%0d, expected valid=%0b hot=%b idx=%0d",
               tag, grantValid, grantOneHot, grantIdx, expValid, expHot, expNum);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    reqVec = '0; xferDone = 1'b0; suspend = 1'b0;
    step();
    step();
    rstN = 1'b1;
    rrModel = 0;
  endtask

  task automatic finishXfer(string tag, int servedIdx);
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;
    rrModel = (servedIdx + 1) % 4;
    expectGrant(tag, 1'b0, 0);
  endtask

  task automatic arbOnce(string tag, logic [3:0] req, logic [1:0] mode, int expIdx);
    reqVec = req;
    prioMode = mode;
    step();
    expectGrant(tag, 1'b1, expIdx);
    finishXfer({tag, " release R8"}, expIdx);
  endtask

  task automatic testReset();
    expectGrant("R1 reset outputs", 1'b0, 0);
  endtask

  task automatic testModeAscend();
    arbOnce("R3 mode00 all", 4'b1111, 2'b00, 0);
    arbOnce("R3 mode00 1..3", 4'b1110, 2'b00, 1);
    arbOnce("R3 mode00 2,3", 4'b1100, 2'b00, 2);
    arbOnce("R3 mode00 3", 4'b1000, 2'b00, 3);
  endtask

  task automatic testModeSplitA();
    arbOnce("R4 mode01 all", 4'b1111, 2'b01, 0);
    arbOnce("R4 mode01 no0", 4'b1110, 2'b01, 2);
    arbOnce("R4 mode01 1,3", 4'b1010, 2'b01, 3);
    arbOnce("R4 mode01 1", 4'b0010, 2'b01, 1);
  endtask

  task automatic testModeSplitB();
    arbOnce("R5 mode10 all", 4'b1111, 2'b10, 2);
    arbOnce("R5 mode10 no2", 4'b1011, 2'b10, 0);
    arbOnce("R5 mode10 1,3", 4'b1010, 2'b10, 1);
    arbOnce("R5 mode10 3", 4'b1000, 2'b10, 3);
  endtask

  task automatic testEligibility();
    chanEn = 4'b1110;
    arbOnce("R2 chanEn masks ch0", 4'b1111, 2'b00, 1);
    chanEn = 4'b1111;
    masterEn = 1'b0;
    reqVec = 4'b1111;
    step();
    expectGrant("R2 masterEn low", 1'b0, 0);
    step();
    expectGrant("R2 masterEn low hold", 1'b0, 0);
    masterEn = 1'b1;
    reqVec = 4'b0000;
  endtask

  task automatic testEmpty();
    reqVec = 4'b0000;
    step();
    expectGrant("R10 no request", 1'b0, 0);
    chanEn = 4'b0000;
    reqVec = 4'b1111;
    step();
    expectGrant("R10 all disabled", 1'b0, 0);
    chanEn = 4'b1111;
    reqVec = 4'b0000;
  endtask

  task automatic testHold();
    reqVec = 4'b0100;
    prioMode = 2'b00;
    step();
    expectGrant("R7 grant appears", 1'b1, 2);
    reqVec = 4'b1111;
    prioMode = 2'b01;
    step();
    expectGrant("R7 holds on new requests", 1'b1, 2);
    reqVec = 4'b0000;
    chanEn = 4'b0000;
    step();
    expectGrant("R7 holds on drop", 1'b1, 2);
    chanEn = 4'b1111;
    reqVec = 4'b0001;
    finishXfer("R8 release after hold", 2);
    step();
    expectGrant("R8 rearbitrates next edge", 1'b1, 0);
    finishXfer("R8 release ch0", 0);
    reqVec = 4'b0000;
  endtask

  task automatic testRotate();
    doReset();
    arbOnce("R1 rotate starts at ch0", 4'b1111, 2'b11, 0);
    for (int k = 0; k < 4; k++) begin
      arbOnce("R6 rotate all", 4'b1111, 2'b11, rrModel);
    end
    // pointer now at 1: ch0 and ch2 request, order 1,2,3,0
    arbOnce("R6 rotate sparse a", 4'b0101, 2'b11, 2);
    // pointer now at 3: order 3,0,1,2
    arbOnce("R6 rotate sparse b", 4'b0101, 2'b11, 0);
  endtask

  task automatic testSuspend();
    // pointer at 1
    reqVec = 4'b1111;
    prioMode = 2'b11;
    step();
    expectGrant("R6 grant before suspend", 1'b1, 1);
    suspend = 1'b1;
    step();
    expectGrant("R9 suspend withdraws", 1'b0, 0);
    xferDone = 1'b1;
    step();
    xferDone = 1'b0;
    expectGrant("R9 no grant while suspended", 1'b0, 0);
    step();
    expectGrant("R9 still suspended", 1'b0, 0);
    suspend = 1'b0;
    step();
    expectGrant("R9 pointer held through suspend", 1'b1, 1);
    finishXfer("R8 release after suspend", 1);
    arbOnce("R6 rotate after suspend", 4'b1111, 2'b11, 2);
    reqVec = 4'b0000;
  endtask

  initial begin
    doReset();
    testReset();
    testModeAscend();
    testModeSplitA();
    testModeSplitB();
    testEligibility();
    testEmpty();
    testHold();
    testRotate();
    testSuspend();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checkCount++;
      failCount++;
      $display("FAIL R7 watchdog: actual still running, expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checkCount, failCount);
      $finish;
    end
  end

endmodule